// File: doc/BRIEF.md
# Latched-address one-hot decoder

This block turns a binary select code into a one-hot set of output lines. The code is held in an address register that is controlled by a level-sensitive load control. While `hold_addr` is low, the register takes the value on `sel` at every rising clock edge. While `hold_addr` is high, it keeps its value. Because the register holds, a bus that later drives other values onto `sel` cannot disturb the outputs.

Two gating inputs of opposite sense decide whether any output may be high. `gate_on` must be high and `gate_off` must be low. The gating acts only on the outputs and never changes the stored code. An elaboration option builds a two-level cascade. In that mode an upper latched decoder takes the upper half of a double-width code, and its lines enable one group each among the lower latched decoders. With three select bits per level, a 6-bit code then drives 64 lines, and every level loads under the same `hold_addr`.

Top module: `ald_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the stored code to 0. Once reset is released, the outputs still follow the gating inputs, so with gating active only line 0 is high.
- R2: At a rising edge where `hold_addr` is low, the stored code takes the value of `sel`. The outputs show the new code from that edge on.
- R3: At a rising edge where `hold_addr` is high, the stored code keeps its value. Any value placed on `sel` while the hold lasts leaves the outputs unchanged.
- R4: Every output line is 0 unless `gate_on` is 1 and `gate_off` is 0. This holds whatever the state of `sel` and `hold_addr`.
- R5: When gating is active, exactly one line is high: line number k, where k is the stored code read as an unsigned binary number with `sel[0]` as the least significant bit. All other lines are low.
- R6: A change on `gate_on` or `gate_off` never changes the stored code. When gating becomes active again, the same line lights as before.
- R7: In cascade mode, `sel` is 2×SEL_W bits wide. The upper SEL_W bits select the group of 2^SEL_W lines, and the lower bits select the line within that group, so line index equals the full code. Every level is controlled by the same hold input.
- R8: When `hold_addr` goes from low to high, the stored code is the value of `sel` at the last rising edge at which `hold_addr` was still low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears the stored code |
| hold_addr | input | 1 | 0: the code register loads `sel` each edge; 1: it holds |
| sel | input | ADDR_W (SEL_W, or 2×SEL_W in cascade) | Binary select code, bit 0 least significant |
| gate_on | input | 1 | Output gating, must be 1 for any line to be high |
| gate_off | input | 1 | Output gating, must be 0 for any line to be high |
| y | output | 2^ADDR_W | One-hot output lines |

## Verification
The bench builds two instances with SEL_W = 3. `dut` uses the cascade mode, with 6 code bits and 64 lines. `dut_flat` uses the single-level mode, with 3 code bits and 8 lines. Both share one stimulus stream, so every hold, load and gating pattern is checked at both widths in the same cycle. The cascade instance reaches all 64 codes, including the group boundaries where the upper level moves on (7 to 8, 55 to 56, 63). Those boundaries show that the upper and lower registers load together under a single hold control.

// File: rtl/ald_pkg.sv
package ald_pkg;

   typedef enum logic {
      ALD_FLAT    = 1'b0,
      ALD_CASCADE = 1'b1
   } ald_mode_e;

   function automatic int unsigned ald_lines(input int unsigned bits);
      return 32'd1 << bits;
   endfunction

endpackage

// File: rtl/ald_addr_store.sv
module ald_addr_store #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         hold,
   input  logic [W-1:0] sel_in,
   output logic [W-1:0] stored
);

   generate
      if (W < 1 || W > 8) begin : g_bad_width
         $error("ald_addr_store: W out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         stored <= '0;
      end else if (!hold) begin
         stored <= sel_in;
      end
   end

   // R1: reset leaves the code at zero
   p_reset_zero_r1: assert property (@(posedge clk)
      $past(rst) |-> stored == '0);

   // R2: transparent phase loads the select value
   p_load_r2: assert property (@(posedge clk) disable iff (rst)
      !hold |=> stored == $past(sel_in));

   // R3 / R8: hold keeps the last loaded code
   p_hold_keeps_r3: assert property (@(posedge clk) disable iff (rst)
      hold |=> $stable(stored));

endmodule

// File: rtl/ald_onehot_gate.sv
module ald_onehot_gate #(
   parameter int unsigned W = 3,
   localparam int unsigned N = ald_pkg::ald_lines(W)
) (
   input  logic [W-1:0] code,
   input  logic         gate_on,
   input  logic         gate_off,
   output logic [N-1:0] lines
);

   logic active;
   assign active = gate_on & ~gate_off;

   generate
      for (genvar g = 0; g < N; g++) begin : g_line
         assign lines[g] = active & (code == W'(g));
      end
   endgenerate

   // R4 / R5: gate-level consistency
   always_comb begin
      if (!active) begin
         a_dark_r4: assert (lines == '0);
      end else begin
         a_single_r5: assert ($countones(lines) == 1);
      end
   end

endmodule

// File: rtl/ald_stage.sv
module ald_stage #(
   parameter int unsigned W = 3,
   localparam int unsigned N = ald_pkg::ald_lines(W)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         hold,
   input  logic [W-1:0] sel_in,
   input  logic         gate_on,
   input  logic         gate_off,
   output logic [N-1:0] lines
);

   logic [W-1:0] code_q;

   ald_addr_store #(.W(W)) u_store (
      .clk    (clk),
      .rst    (rst),
      .hold   (hold),
      .sel_in (sel_in),
      .stored (code_q)
   );

   ald_onehot_gate #(.W(W)) u_gate (
      .code     (code_q),
      .gate_on  (gate_on),
      .gate_off (gate_off),
      .lines    (lines)
   );

endmodule

// File: rtl/ald_decoder.sv
module ald_decoder #(
   parameter int unsigned        SEL_W = 3,
   parameter ald_pkg::ald_mode_e MODE  = ald_pkg::ALD_FLAT,
   localparam int unsigned ADDR_W = (MODE == ald_pkg::ALD_CASCADE) ? 2 * SEL_W : SEL_W,
   localparam int unsigned OUT_W  = ald_pkg::ald_lines(ADDR_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold_addr,
   input  logic [ADDR_W-1:0] sel,
   input  logic              gate_on,
   input  logic              gate_off,
   output logic [OUT_W-1:0]  y
);

   localparam int unsigned GRP_N = ald_pkg::ald_lines(SEL_W);

   generate
      if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
         $error("ald_decoder: SEL_W out of range");
      end

      if (MODE == ald_pkg::ALD_FLAT) begin : g_flat
         ald_stage #(.W(SEL_W)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .hold     (hold_addr),
            .sel_in   (sel),
            .gate_on  (gate_on),
            .gate_off (gate_off),
            .lines    (y)
         );
      end else begin : g_cascade
         logic [GRP_N-1:0] grp_en;

         // upper level: picks the group, carries the external gating
         ald_stage #(.W(SEL_W)) u_upper (
            .clk      (clk),
            .rst      (rst),
            .hold     (hold_addr),
            .sel_in   (sel[ADDR_W-1:SEL_W]),
            .gate_on  (gate_on),
            .gate_off (gate_off),
            .lines    (grp_en)
         );

         // lower level: one latched decoder per group
         for (genvar g = 0; g < GRP_N; g++) begin : g_grp
            ald_stage #(.W(SEL_W)) u_lower (
               .clk      (clk),
               .rst      (rst),
               .hold     (hold_addr),
               .sel_in   (sel[SEL_W-1:0]),
               .gate_on  (grp_en[g]),
               .gate_off (1'b0),
               .lines    (y[g*GRP_N +: GRP_N])
            );
         end
      end
   endgenerate

   // R4: outputs dark whenever gating is inactive
   p_dark_r4: assert property (@(posedge clk) disable iff (rst)
      !(gate_on && !gate_off) |-> y == '0);

   // R5 / R7: exactly one line when gating is active
   p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
      (gate_on && !gate_off) |-> $countones(y) == 1);

   // R2 / R7: loaded code selects its line on the next edge
   p_line_follows_r7: assert property (@(posedge clk) disable iff (rst)
      (!hold_addr && gate_on && !gate_off) ##1 (gate_on && !gate_off)
         |-> y[$past(sel)]);

   // R3: held code keeps the lit line while gating stays active
   p_hold_line_r3: assert property (@(posedge clk) disable iff (rst)
      (hold_addr && gate_on && !gate_off) ##1 (gate_on && !gate_off)
         |-> y == $past(y));

endmodule

// File: tb/tb_ald_decoder.sv
module tb_ald_decoder;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        hold_addr = 1'b0;
   logic [5:0]  sel = '0;
   logic        gate_on = 1'b1;
   logic        gate_off = 1'b0;
   logic [63:0] y_c;
   logic [7:0]  y_f;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ald_decoder #(.SEL_W(3), .MODE(ald_pkg::ALD_CASCADE)) dut (
      .clk(clk), .rst(rst), .hold_addr(hold_addr), .sel(sel),
      .gate_on(gate_on), .gate_off(gate_off), .y(y_c)
   );

   ald_decoder #(.SEL_W(3), .MODE(ald_pkg::ALD_FLAT)) dut_flat (
      .clk(clk), .rst(rst), .hold_addr(hold_addr), .sel(sel[2:0]),
      .gate_on(gate_on), .gate_off(gate_off), .y(y_f)
   );

   // behavioural reference: remembered code per width
   int m_c = 0;
   int m_f = 0;
   always @(posedge clk) begin
      if (rst) begin
         m_c <= 0;
         m_f <= 0;
      end else if (!hold_addr) begin
         m_c <= int'(sel);
         m_f <= int'(sel[2:0]);
      end
   end

   task automatic check(input string tag);
      logic [63:0] e_c;
      logic [7:0]  e_f;
      e_c = (gate_on && !gate_off) ? (64'd1 << m_c) : 64'd0;
      e_f = (gate_on && !gate_off) ? (8'd1 << m_f) : 8'd0;
      n_cmp++;
      if (y_c !== e_c) begin
         n_bad++;
         $display("FAIL %s cascade: actual %h expected %h", tag, y_c, e_c);
      end
      n_cmp++;
      if (y_f !== e_f) begin
         n_bad++;
         $display("FAIL %s flat: actual %h expected %h", tag, y_f, e_f);
      end
   endtask

   task automatic cyc(input logic h, input logic [5:0] s,
                      input logic on, input logic off, input string tag);
      hold_addr = h;
      sel       = s;
      gate_on   = on;
      gate_off  = off;
      @(posedge clk);
      #2;
      check(tag);
   endtask

   initial begin
      // R1: reset with a nonzero select on the bus
      rst = 1'b1;
      cyc(1'b0, 6'd45, 1'b1, 1'b0, "R1");
      cyc(1'b0, 6'd45, 1'b1, 1'b0, "R1");
      rst = 1'b0;
      cyc(1'b1, 6'd12, 1'b1, 1'b0, "R1");

      // R2 / R5: loads in transparent phase, distinct patterns
      cyc(1'b0, 6'd0,  1'b1, 1'b0, "R2");
      cyc(1'b0, 6'd1,  1'b1, 1'b0, "R5");
      cyc(1'b0, 6'd7,  1'b1, 1'b0, "R7");
      cyc(1'b0, 6'd8,  1'b1, 1'b0, "R7");
      cyc(1'b0, 6'd55, 1'b1, 1'b0, "R7");
      cyc(1'b0, 6'd56, 1'b1, 1'b0, "R7");
      cyc(1'b0, 6'd63, 1'b1, 1'b0, "R5");
      cyc(1'b0, 6'd42, 1'b1, 1'b0, "R2");

      // R8 / R3: capture 45, then hold while the bus moves
      cyc(1'b0, 6'd45, 1'b1, 1'b0, "R8");
      cyc(1'b1, 6'd2,  1'b1, 1'b0, "R8");
      for (int i = 0; i < 6; i++) begin
         cyc(1'b1, 6'(i * 11 + 3), 1'b1, 1'b0, "R3");
      end

      // R4: every inactive gating combination, held and transparent
      cyc(1'b1, 6'd9,  1'b0, 1'b0, "R4");
      cyc(1'b1, 6'd9,  1'b1, 1'b1, "R4");
      cyc(1'b1, 6'd9,  1'b0, 1'b1, "R4");
      cyc(1'b0, 6'd20, 1'b0, 1'b0, "R4");
      cyc(1'b0, 6'd21, 1'b1, 1'b1, "R4");

      // R6: gating changes leave the code alone
      cyc(1'b1, 6'd0,  1'b1, 1'b0, "R6");
      cyc(1'b1, 6'd0,  1'b0, 1'b1, "R6");
      cyc(1'b1, 6'd0,  1'b1, 1'b0, "R6");

      // R7: sweep every cascade code
      for (int a = 0; a < 64; a++) begin
         cyc(1'b0, 6'(a), 1'b1, 1'b0, "R7");
      end
      for (int a = 63; a >= 0; a -= 9) begin
         cyc(1'b0, 6'(a), 1'b1, 1'b0, "R7");
         cyc(1'b1, 6'(63 - a), 1'b1, 1'b0, "R3");
      end

      // R1: reset again mid-run, outputs still obey gating
      rst = 1'b1;
      cyc(1'b1, 6'd30, 1'b1, 1'b0, "R1");
      rst = 1'b0;
      cyc(1'b1, 6'd30, 1'b0, 1'b0, "R1");
      cyc(1'b1, 6'd30, 1'b1, 1'b0, "R1");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule